// File: doc/BRIEF.md
# Prescaled Triple Interval Timer

This block holds three periodic down-counters that share one slow tick. The tick is made by dividing the system clock by 32 times an 8-bit divider, and a divider of zero behaves the same as one. Timer A is 16 bits wide and counts ticks directly. A 12-bit prescaler also counts ticks and gives a strobe each time it wraps. Timers B (4 bits) and C (16 bits) advance only on that strobe.

Each counter steps down on its own enable. When an enabled step finds it at zero, it reloads from its load inputs and raises a one-cycle set pulse on its output. The register file that holds the load and run values, and any interrupt masking of the pulses, belong to the surrounding logic. This block takes those values as plain inputs and drives only the three set pulses.

The 8-bit timer-B configuration input serves two purposes. Its upper nibble is the 4-bit reload of timer B. Its lower nibble gives bits 11:8 of the prescaler reload, and bits 7:0 of that reload come from a separate prescaler input.

Top module: `prescaled_triple_timer`

## Requirements
- R1: A tick occurs once every 32*D input clocks, where D is `clk_div`. When `clk_div` is 0, D is taken as 1.
- R2: While `run_ctrl[0]` is 1, timer A decrements on every tick. A tick that finds it at zero instead reloads it with `a_load` and sets `a_set`, so pulses on `a_set` are (a_load+1) ticks apart.
- R3: The prescaler steps only on ticks while `run_ctrl[3]` is 1. At zero it reloads with {`b_cfg[3:0]`, `pre_load[7:0]`} and gives one strobe. A strobe happens only in a tick cycle.
- R4: Timer B steps only on a prescaler strobe while `run_ctrl[1]` is 1. At zero it reloads with `b_cfg[7:4]` and sets `b_set`, so its pulses are (b_cfg[7:4]+1)*(prescaler reload+1) ticks apart.
- R5: Timer C steps only on a prescaler strobe while `run_ctrl[2]` is 1. At zero it reloads with `c_load` and sets `c_set`, so its pulses are (c_load+1)*(prescaler reload+1) ticks apart.
- R6: Reset clears every counter and all outputs. After reset is released with `clk_div`=1 and `run_ctrl[0]`=1, the first `a_set` pulse is seen in the 33rd cycle.
- R7: While `run_ctrl[3]` is 0, neither `b_set` nor `c_set` is ever raised, whatever `run_ctrl[1]` and `run_ctrl[2]` hold.
- R8: Clearing a run bit freezes that counter at its current value. No pulse appears while it is frozen, and counting resumes from the held value.
- R9: The set pulses are registered. Each one is high for exactly one cycle and appears one cycle after the tick cycle that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 8 | Tick divider; tick period is 32*clk_div clocks (0 acts as 1) |
| run_ctrl | input | 4 | Run enables: bit0 timer A, bit1 timer B, bit2 timer C, bit3 prescaler |
| a_load | input | 16 | Timer A reload value |
| b_cfg | input | 8 | [7:4] timer B reload, [3:0] prescaler reload bits 11:8 |
| pre_load | input | 8 | Prescaler reload bits 7:0 |
| c_load | input | 16 | Timer C reload value |
| a_set | output | 1 | One-cycle expiry pulse of timer A |
| b_set | output | 1 | One-cycle expiry pulse of timer B |
| c_set | output | 1 | One-cycle expiry pulse of timer C |

## Verification
The bench first targets the cycle of the first pulse after reset, because counters start at zero. A design that decremented before testing for zero would pulse a whole reload period late. It measures the spacing between pulses with divider 0, 1 and 3, which shows a divide-by-zero error or an off-by-one in the period. It also loads the prescaler through the lower nibble of `b_cfg`, so a design that swapped the nibbles would give a period many times longer or shorter. A stopped prescaler with timers B and C enabled must give no pulse at all, and a frozen timer A must hold its count: a design that reset the counter on stop would resume early, and this is caught by a reference model checked every cycle under random configurations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int RUN_A    = 0;
  localparam int RUN_B    = 1;
  localparam int RUN_C    = 2;
  localparam int RUN_PRE  = 3;
  localparam int RUN_BITS = 4;
  localparam int PRE_LOG2 = 5;   // fixed 32x pre-divider
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_W    = 8,
  parameter int PRE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = DIV_W + PRE_LOG2;

  logic [DIV_W-1:0] eff_div;
  logic [CW-1:0]    period;
  logic [CW-1:0]    cnt;
  logic             at_end;

  always_comb begin
    eff_div = (div == '0) ? DIV_W'(1) : div;
    period  = {{PRE_LOG2{1'b0}}, eff_div} << PRE_LOG2;
    at_end  = (cnt >= period - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= at_end;
      cnt  <= at_end ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= reload;
    else if (step) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/prescaled_triple_timer.sv
module prescaled_triple_timer
  import tmr_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int A_W   = 16,
  parameter int B_W   = 4,
  parameter int PRE_W = 12,
  parameter int C_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic [RUN_BITS-1:0] run_ctrl,
  input  logic [A_W-1:0]      a_load,
  input  logic [2*B_W-1:0]    b_cfg,
  input  logic [PRE_W-B_W-1:0] pre_load,
  input  logic [C_W-1:0]      c_load,
  output logic                a_set,
  output logic                b_set,
  output logic                c_set
);
  logic             tick;
  logic             a_wrap, base_wrap, b_wrap, c_wrap;
  logic [PRE_W-1:0] pre_reload;

  assign pre_reload = {b_cfg[B_W-1:0], pre_load};

  tmr_tick_gen #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) u_tick (
    .clk(clk), .rst(rst), .div(clk_div), .tick(tick));

  tmr_countdown #(.W(A_W)) u_a (
    .clk(clk), .rst(rst), .step(tick && run_ctrl[RUN_A]),
    .reload(a_load), .wrap(a_wrap));

  tmr_countdown #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .step(tick && run_ctrl[RUN_PRE]),
    .reload(pre_reload), .wrap(base_wrap));

  tmr_countdown #(.W(B_W)) u_b (
    .clk(clk), .rst(rst), .step(base_wrap && run_ctrl[RUN_B]),
    .reload(b_cfg[2*B_W-1:B_W]), .wrap(b_wrap));

  tmr_countdown #(.W(C_W)) u_c (
    .clk(clk), .rst(rst), .step(base_wrap && run_ctrl[RUN_C]),
    .reload(c_load), .wrap(c_wrap));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_set <= 1'b0;
      b_set <= 1'b0;
      c_set <= 1'b0;
    end else begin
      a_set <= a_wrap;
      b_set <= b_wrap;
      c_set <= c_wrap;
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] run_ctrl,
  input logic       tick,
  input logic       base_wrap,
  input logic       a_set,
  input logic       b_set,
  input logic       c_set
);
  assert_reset_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !a_set && !b_set && !c_set);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (a_set || b_set || c_set) |=> !a_set && !b_set && !c_set);

  assert_strobe_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    base_wrap |-> tick);

  assert_b_needs_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    b_set |-> $past(base_wrap));

  assert_c_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    c_set |-> $past(base_wrap));

  assert_base_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(run_ctrl[3]) |-> !b_set && !c_set);

  assert_frozen_a_R8: assert property (@(posedge clk) disable iff (rst)
    !run_ctrl[0] |=> !a_set);
endmodule

bind prescaled_triple_timer tmr_checker u_chk (
  .clk(clk), .rst(rst), .run_ctrl(run_ctrl), .tick(tick),
  .base_wrap(base_wrap), .a_set(a_set), .b_set(b_set), .c_set(c_set));

// File: tb/prescaled_triple_timer_tb.sv
module prescaled_triple_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clk_div = 8'd1;
  logic [3:0]  run_ctrl = 4'd0;
  logic [15:0] a_load = '0;
  logic [7:0]  b_cfg = '0;
  logic [7:0]  pre_load = '0;
  logic [15:0] c_load = '0;
  logic        a_set, b_set, c_set;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_triple_timer dut_i (
    .clk(clk), .rst(rst), .clk_div(clk_div), .run_ctrl(run_ctrl),
    .a_load(a_load), .b_cfg(b_cfg), .pre_load(pre_load), .c_load(c_load),
    .a_set(a_set), .b_set(b_set), .c_set(c_set));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model built from the requirements
  int mcnt, ma, mpre, mb, mc;
  bit mtick, ea, eb, ec;

  function automatic int period_of(input logic [7:0] d);
    return 32 * ((d == 0) ? 1 : int'(d));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mcnt = 0; mtick = 0; ma = 0; mpre = 0; mb = 0; mc = 0;
      ea = 0; eb = 0; ec = 0;
    end else begin
      bit wa, wp, wb, wc;
      wa = mtick && run_ctrl[0] && ma == 0;
      wp = mtick && run_ctrl[3] && mpre == 0;
      wb = wp && run_ctrl[1] && mb == 0;
      wc = wp && run_ctrl[2] && mc == 0;
      if (mtick && run_ctrl[0]) ma = wa ? int'(a_load) : ma - 1;
      if (wp && run_ctrl[1]) mb = wb ? int'(b_cfg[7:4]) : mb - 1;
      if (wp && run_ctrl[2]) mc = wc ? int'(c_load) : mc - 1;
      if (mtick && run_ctrl[3]) mpre = wp ? int'({b_cfg[3:0], pre_load}) : mpre - 1;
      ea = wa; eb = wb; ec = wc;
      mtick = (mcnt >= period_of(clk_div) - 1);
      mcnt  = mtick ? 0 : mcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(a_set == ea, "R2 a_set vs model", int'(a_set), int'(ea));
      check(b_set == eb, "R4 b_set vs model", int'(b_set), int'(eb));
      check(c_set == ec, "R5 c_set vs model", int'(c_set), int'(ec));
    end
    if (cyc > WATCHDOG) begin
      check(0, "watchdog", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic bit pulse_of(input int which);
    return (which == 0) ? a_set : (which == 1) ? b_set : c_set;
  endfunction

  task automatic wait_pulse(input int which, input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (pulse_of(which)) begin at = cyc; return; end
    end
  endtask

  task automatic measure(input int which, input int exp, input string req);
    int t1, t2;
    wait_pulse(which, 20000, t1);
    wait_pulse(which, 20000, t2);
    check(t1 >= 0 && t2 >= 0 && (t2 - t1) == exp, req, t2 - t1, exp);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt += int'(a_set) + int'(b_set) + int'(c_set);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    run_ctrl = 4'd0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n, first;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(a_set == 0 && b_set == 0 && c_set == 0, "R6 outputs in reset",
          int'({a_set, b_set, c_set}), 0);

    // R6: first pulse right after reset release
    clk_div = 8'd1; a_load = 16'd5; run_ctrl = 4'b0001;
    rst = 1'b0;
    first = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (a_set && first == 0) first = i;
    end
    check(first == 33, "R6 first a_set cycle", first, 33);

    // R2 timer A interval
    measure(0, 6 * 32, "R2 a_set spacing load 5");
    // R1 divider 3 and divider 0
    clk_div = 8'd3; a_load = 16'd1;
    measure(0, 2 * 96, "R1 spacing divider 3");
    clk_div = 8'd0;
    measure(0, 2 * 32, "R1 spacing divider 0");

    // R4 timer B through prescaler
    do_reset();
    rst = 1'b0; clk_div = 8'd1; b_cfg = 8'h10; pre_load = 8'd3;
    run_ctrl = 4'b1010;
    measure(1, 2 * 4 * 32, "R4 b_set spacing");
    // R3 prescaler upper bits from low nibble of b_cfg
    b_cfg = 8'h01; pre_load = 8'd0;
    measure(1, 257 * 32, "R3 prescaler reload 0x100");

    // R5 timer C
    run_ctrl = 4'b1100; b_cfg = 8'h00; pre_load = 8'd3; c_load = 16'd2;
    measure(2, 3 * 4 * 32, "R5 c_set spacing");

    // R7 prescaler stopped
    run_ctrl = 4'b0110;
    repeat (2) @(negedge clk);
    count_pulses(3000, n);
    check(n == 0, "R7 no b/c pulse with prescaler stopped", n, 0);

    // R8 freeze and resume of timer A
    run_ctrl = 4'b0001; a_load = 16'd20;
    wait_pulse(0, 2000, first);
    run_ctrl = 4'b0000;
    count_pulses(800, n);
    check(n == 0, "R8 no pulse while frozen", n, 0);
    run_ctrl = 4'b0001;
    wait_pulse(0, 2000, first);
    check(first >= 0, "R8 resumes after freeze", first >= 0, 1);

    // Random configurations against the model
    for (int s = 0; s < 30; s++) begin
      @(negedge clk);
      clk_div  = 8'($urandom % 4);
      run_ctrl = 4'($urandom);
      a_load   = 16'($urandom % 40);
      b_cfg    = {4'($urandom), (($urandom % 8) == 0) ? 4'd1 : 4'd0};
      pre_load = 8'($urandom % 8);
      c_load   = 16'($urandom % 8);
      if (s == 15) do_reset();
      rst = 1'b0;
      repeat (1500) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule